// File: doc/BRIEF.md
# Privilege and Stack Pointer Selector

This block keeps the processor's privilege state as two status bits, the supervisor bit S and the master bit M. It uses those bits to choose which of three stack pointer registers is the active one: the user stack pointer, the interrupt stack pointer or the master stack pointer. The master stack is meant to hold per-task supervisor data. The interrupt stack is shared by interrupt handlers.

The two bits change at four kinds of event: reset, exception entry, a status-register write and a return from exception. The block also raises a privilege-violation flag when a privileged operation is tried at user level. Instruction decode, the bus and vector fetch are outside the block. The decoder presents an operation class and the new bit values. The exception sequencer presents the entry strobes.

The bits are held as a four-state machine whose state encoding is {S,M}:
- `ST_USR_I` is user level with M clear.
- `ST_USR_M` is user level with M set.
- `ST_SUP_I` is supervisor interrupt mode, and is the reset state.
- `ST_SUP_M` is supervisor master mode.

The transitions are as follows:
- Any state goes to `ST_SUP_I` on an interrupt entry.
- A user state goes to the supervisor state with the same M on a non-interrupt entry: `ST_USR_I`→`ST_SUP_I` and `ST_USR_M`→`ST_SUP_M`.
- A supervisor state goes to the state named by the new bits on a status write or a return from exception.
- In every other case the state holds.

Top module: `priv_sp_unit`

## Requirements
- R1: After reset S=1 and M=0, `sp_sel` is 1 (interrupt stack) and all three stack pointers read as zero.
- R2: `sp_sel` encodes 0 = user, 1 = interrupt, 2 = master. S=0 selects user, S=1 with M=0 selects interrupt, and S=1 with M=1 selects master. `sp_rd_data` shows the selected register.
- R3: A stack pointer write changes only the register selected in that cycle, and the new value is visible on the next cycle. The other two registers keep their values.
- R4: On an interrupt entry (`exc_entry`=1, `exc_irq`=1), the next cycle has S=1 and M=0. `saved_s`/`saved_m` then hold the S and M values from before the entry.
- R5: On a non-interrupt entry (`exc_entry`=1, `exc_irq`=0), the next cycle has S=1 with M unchanged, and `saved_s`/`saved_m` hold the earlier bits.
- R6: At supervisor level, an `op_class` of 2 (status write) or 3 (return from exception) loads S and M from `new_s`/`new_m`. The stack selection follows on the next cycle.
- R7: At user level, `op_class` 2 or 3 leaves S and M unchanged.
- R8: `priv_viol` is high in the same cycle exactly when S=0 and `op_class` is 2, 3, 4 (stop) or 5 (reset). It stays low for 0 (none), 1 (other) and 6 (trap), and it stays low at supervisor level.
- R9: When an exception entry and a status write or return fall in the same cycle, the exception entry decides the new bits.
- R10: A stack write in the same cycle as a mode change goes to the pointer that was selected before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 3 | Decoded operation class (0 none, 1 other, 2 status write, 3 return, 4 stop, 5 reset, 6 trap) |
| new_s | input | 1 | S value for a status write or return |
| new_m | input | 1 | M value for a status write or return |
| exc_entry | input | 1 | Exception entry strobe |
| exc_irq | input | 1 | The entry is an interrupt |
| sp_wr_en | input | 1 | Write the active stack pointer |
| sp_wr_data | input | SP_W | Stack pointer write data |
| sp_rd_data | output | SP_W | Active stack pointer value |
| sp_sel | output | 2 | Active stack pointer select |
| sup_s | output | 1 | Current S bit |
| sup_m | output | 1 | Current M bit |
| saved_s | output | 1 | S before the last exception entry |
| saved_m | output | 1 | M before the last exception entry |
| priv_viol | output | 1 | Privilege violation flag |

## Verification
Two pairs of functions can act in the same cycle. The first pair is an exception entry and a mode write. The second pair is a stack pointer write and a change of mode. The bench raises both members of each pair in one cycle. For the first pair, it then checks that the resulting S and M are those the entry alone would give. For the second pair, it reads back every stack pointer by moving through the modes, to confirm that the write landed in the register selected before the edge and that the other two registers did not change.

// File: rtl/priv_pkg.sv
package priv_pkg;
    typedef enum logic [1:0] {
        ST_USR_I = 2'b00,
        ST_USR_M = 2'b01,
        ST_SUP_I = 2'b10,
        ST_SUP_M = 2'b11
    } mode_state_t;

    typedef enum logic [1:0] {
        SEL_USP = 2'd0,
        SEL_ISP = 2'd1,
        SEL_MSP = 2'd2
    } sp_sel_t;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_OTHER = 3'd1,
        OPC_SRWR  = 3'd2,
        OPC_RTE   = 3'd3,
        OPC_STOP  = 3'd4,
        OPC_RESET = 3'd5,
        OPC_TRAP  = 3'd6
    } op_class_t;
endpackage

// File: rtl/priv_gate.sv
module priv_gate
    import priv_pkg::*;
(
    input  logic [2:0] op_class,
    input  logic       sup_s,
    output logic       mode_wr_req,
    output logic       priv_viol
);
    logic privileged;

    always_comb begin
        privileged  = 1'b0;
        mode_wr_req = 1'b0;
        unique case (op_class_t'(op_class))
            OPC_SRWR, OPC_RTE: begin
                privileged  = 1'b1;
                mode_wr_req = 1'b1;
            end
            OPC_STOP, OPC_RESET: privileged = 1'b1;
            default: ;
        endcase
        priv_viol = privileged && !sup_s;
    end
endmodule

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_entry,
    input  logic exc_irq,
    input  logic mode_wr_req,
    input  logic new_s,
    input  logic new_m,
    output logic sup_s,
    output logic sup_m,
    output logic saved_s,
    output logic saved_m,
    output logic [1:0] sp_sel
);
    mode_state_t state, state_nx;
    logic        sav_s_q, sav_m_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_USR_I, ST_USR_M: begin
                if (exc_entry)
                    state_nx = exc_irq ? ST_SUP_I
                             : ((state == ST_USR_M) ? ST_SUP_M : ST_SUP_I);
            end
            ST_SUP_I, ST_SUP_M: begin
                if (exc_entry) begin
                    if (exc_irq) state_nx = ST_SUP_I;
                end else if (mode_wr_req) begin
                    state_nx = mode_state_t'({new_s, new_m});
                end
            end
            default: state_nx = ST_SUP_I;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SUP_I;
            sav_s_q <= 1'b1;
            sav_m_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (exc_entry) begin
                sav_s_q <= state[1];
                sav_m_q <= state[0];
            end
        end
    end

    always_comb begin
        saved_s = sav_s_q;
        saved_m = sav_m_q;
        unique case (state)
            ST_USR_I: begin sup_s = 1'b0; sup_m = 1'b0; sp_sel = SEL_USP; end
            ST_USR_M: begin sup_s = 1'b0; sup_m = 1'b1; sp_sel = SEL_USP; end
            ST_SUP_I: begin sup_s = 1'b1; sup_m = 1'b0; sp_sel = SEL_ISP; end
            ST_SUP_M: begin sup_s = 1'b1; sup_m = 1'b1; sp_sel = SEL_MSP; end
            default:  begin sup_s = 1'b1; sup_m = 1'b0; sp_sel = SEL_ISP; end
        endcase
    end

    assert_irq_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && exc_irq) |=> (sup_s && !sup_m && saved_s == $past(sup_s)
                                    && saved_m == $past(sup_m)));

    assert_plain_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !exc_irq) |=> (sup_s && sup_m == $past(sup_m)));

    assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_s && mode_wr_req && !exc_entry) |=> $stable(state));

    assert_entry_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && mode_wr_req) |=> sup_s);
endmodule

// File: rtl/sp_bank.sv
module sp_bank
    import priv_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      sp_sel,
    input  logic            wr_en,
    input  logic [SP_W-1:0] wr_data,
    output logic [SP_W-1:0] rd_data
);
    localparam int NUM_SP = 3;

    logic [SP_W-1:0] sp_q [NUM_SP];

    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
        always_ff @(posedge clk) begin
            if (!rst_n)
                sp_q[g] <= '0;
            else if (wr_en && sp_sel == g[1:0])
                sp_q[g] <= wr_data;
        end
    end

    always_comb begin
        unique case (sp_sel_t'(sp_sel))
            SEL_USP: rd_data = sp_q[0];
            SEL_ISP: rd_data = sp_q[1];
            SEL_MSP: rd_data = sp_q[2];
            default: rd_data = sp_q[1];
        endcase
    end

    assert_user_sp_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sp_sel != SEL_USP) |=> $stable(sp_q[0]));

    assert_master_sp_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sp_sel != SEL_MSP) |=> $stable(sp_q[2]));
endmodule

// File: rtl/priv_sp_unit.sv
module priv_sp_unit
    import priv_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_class,
    input  logic            new_s,
    input  logic            new_m,
    input  logic            exc_entry,
    input  logic            exc_irq,
    input  logic            sp_wr_en,
    input  logic [SP_W-1:0] sp_wr_data,
    output logic [SP_W-1:0] sp_rd_data,
    output logic [1:0]      sp_sel,
    output logic            sup_s,
    output logic            sup_m,
    output logic            saved_s,
    output logic            saved_m,
    output logic            priv_viol
);
    logic mode_wr_req;

    priv_gate u_gate (
        .op_class   (op_class),
        .sup_s      (sup_s),
        .mode_wr_req(mode_wr_req),
        .priv_viol  (priv_viol)
    );

    priv_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_entry  (exc_entry),
        .exc_irq    (exc_irq),
        .mode_wr_req(mode_wr_req),
        .new_s      (new_s),
        .new_m      (new_m),
        .sup_s      (sup_s),
        .sup_m      (sup_m),
        .saved_s    (saved_s),
        .saved_m    (saved_m),
        .sp_sel     (sp_sel)
    );

    sp_bank #(.SP_W(SP_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sp_sel (sp_sel),
        .wr_en  (sp_wr_en),
        .wr_data(sp_wr_data),
        .rd_data(sp_rd_data)
    );

    assert_viol_only_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> !sup_s);

    assert_sel_follows_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_sel == 2'd0) == !sup_s);
endmodule

// File: tb/sim_priv_sp_unit.sv
module sim_priv_sp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        new_s = 1'b0, new_m = 1'b0;
    logic        exc_entry = 1'b0, exc_irq = 1'b0;
    logic        sp_wr_en = 1'b0;
    logic [31:0] sp_wr_data = '0;
    logic [31:0] sp_rd_data;
    logic [1:0]  sp_sel;
    logic        sup_s, sup_m, saved_s, saved_m, priv_viol;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] V_ISP = 32'h0000_1A00;
    localparam logic [31:0] V_MSP = 32'h0000_2B00;
    localparam logic [31:0] V_USP = 32'h0000_3C00;
    localparam logic [31:0] V_ISP2 = 32'h0000_4D00;

    always #5 clk = ~clk;

    priv_sp_unit #(.SP_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .new_s(new_s), .new_m(new_m),
        .exc_entry(exc_entry), .exc_irq(exc_irq), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data), .sp_sel(sp_sel),
        .sup_s(sup_s), .sup_m(sup_m), .saved_s(saved_s), .saved_m(saved_m),
        .priv_viol(priv_viol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        op_class = 3'd0; new_s = 1'b0; new_m = 1'b0;
        exc_entry = 1'b0; exc_irq = 1'b0; sp_wr_en = 1'b0; sp_wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        clr();
    endtask

    task automatic mode_wr(input logic [2:0] opc, input logic s, input logic m);
        op_class = opc; new_s = s; new_m = m;
        tick();
    endtask

    task automatic sp_write(input logic [31:0] v);
        sp_wr_en = 1'b1; sp_wr_data = v;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 S", {31'd0, sup_s}, 32'd1);
        chk("R1 M", {31'd0, sup_m}, 32'd0);
        chk("R1 sel", {30'd0, sp_sel}, 32'd1);
        chk("R1 sp", sp_rd_data, 32'd0);
    endtask

    task automatic t_select_write();
        sp_write(V_ISP);
        chk("R3 isp written", sp_rd_data, V_ISP);
        mode_wr(3'd2, 1'b1, 1'b1);
        chk("R6 master sel", {30'd0, sp_sel}, 32'd2);
        chk("R3 msp untouched", sp_rd_data, 32'd0);
        sp_write(V_MSP);
        chk("R2 msp read", sp_rd_data, V_MSP);
        mode_wr(3'd2, 1'b0, 1'b1);
        chk("R2 user sel", {30'd0, sp_sel}, 32'd0);
        chk("R3 usp untouched", sp_rd_data, 32'd0);
        sp_write(V_USP);
        chk("R2 usp read", sp_rd_data, V_USP);
    endtask

    task automatic t_user_guard();
        op_class = 3'd4; #1;
        chk("R8 stop at user", {31'd0, priv_viol}, 32'd1);
        op_class = 3'd5; #1;
        chk("R8 reset at user", {31'd0, priv_viol}, 32'd1);
        op_class = 3'd6; #1;
        chk("R8 trap at user", {31'd0, priv_viol}, 32'd0);
        op_class = 3'd1; #1;
        chk("R8 other at user", {31'd0, priv_viol}, 32'd0);
        op_class = 3'd2; new_s = 1'b1; new_m = 1'b0; #1;
        chk("R8 srwr at user", {31'd0, priv_viol}, 32'd1);
        tick();
        chk("R7 srwr ignored S", {31'd0, sup_s}, 32'd0);
        chk("R7 srwr ignored M", {31'd0, sup_m}, 32'd1);
        mode_wr(3'd3, 1'b1, 1'b0);
        chk("R7 rte ignored", {30'd0, sup_s, sup_m}, 32'd1);
    endtask

    task automatic t_exceptions();
        exc_entry = 1'b1; exc_irq = 1'b0;
        tick();
        chk("R5 S/M", {30'd0, sup_s, sup_m}, 32'd3);
        chk("R5 saved", {30'd0, saved_s, saved_m}, 32'd1);
        chk("R5 msp active", sp_rd_data, V_MSP);
        op_class = 3'd4; #1;
        chk("R8 stop at supervisor", {31'd0, priv_viol}, 32'd0);
        clr();
        exc_entry = 1'b1; exc_irq = 1'b1;
        tick();
        chk("R4 S/M", {30'd0, sup_s, sup_m}, 32'd2);
        chk("R4 saved", {30'd0, saved_s, saved_m}, 32'd3);
        chk("R4 isp active", sp_rd_data, V_ISP);
    endtask

    task automatic t_collide();
        exc_entry = 1'b1; exc_irq = 1'b0;
        op_class = 3'd2; new_s = 1'b0; new_m = 1'b1;
        tick();
        chk("R9 entry wins", {30'd0, sup_s, sup_m}, 32'd2);
        op_class = 3'd2; new_s = 1'b1; new_m = 1'b1;
        sp_wr_en = 1'b1; sp_wr_data = V_ISP2;
        tick();
        chk("R10 msp kept", sp_rd_data, V_MSP);
        exc_entry = 1'b1; exc_irq = 1'b1;
        tick();
        chk("R10 isp took write", sp_rd_data, V_ISP2);
        mode_wr(3'd3, 1'b0, 1'b0);
        chk("R6 rte to user", {30'd0, sp_sel}, 32'd0);
        chk("R3 usp kept", sp_rd_data, V_USP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr();
        #2;
        t_reset();
        t_select_write();
        t_user_guard();
        t_exceptions();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule